// File: doc/BRIEF.md
# Register-Immediate Execution Unit with Status Flags

This unit runs one register-immediate operation per accepted strobe on a 32-bit register operand and an 8-bit immediate. The operation is chosen by a second opcode byte. The supported operations are bitwise AND, OR and XOR, arithmetic and logical right shift, left shift, and signed and unsigned multiply. The result, the four status flags and, for multiplies, the upper product word are registered one clock edge after the strobe.

The register file and the status word stay with the surrounding harness. The harness reads the operand, the incoming carry and the incoming overflow, and presents them together with the opcode byte and the immediate. After the unit responds, it writes back the result, the flags and, when the high-word write enable is raised, the multiply-high register.

Each operation has its own rule for updating the flags. The carry produced by either right shift is always bit 0 of the operand before the shift, whatever the shift amount.

Top module: `immop_exec`

## Requirements
- R1: An opcode byte is accepted only when its low nibble is 0x9 and its high nibble is one of 0x0 (AND), 0x1 (OR), 0x2 (XOR), 0x4 (arithmetic right shift), 0x5 (logical right shift), 0x6 (left shift), 0xA (signed multiply) or 0xB (unsigned multiply). Any other byte is ignored: `res_valid` and `hi_we` stay low, and `result`, `flags_out` and `hi_word` keep their values.
- R2: An accepted operation presented with `op_valid` at a rising edge raises `res_valid` for exactly one cycle after that edge, with `result` and `flags_out` updated at the same edge. A synchronous active-low reset clears `res_valid`, `hi_we`, `result`, `flags_out` and `hi_word` to zero.
- R3: AND, OR and XOR combine the operand with the zero-extended immediate, and clear both C and V.
- R4: For every operation, flag Z (`flags_out[0]`) is 1 exactly when all 32 result bits are zero, and flag N (`flags_out[1]`) equals bit 31 of the result.
- R5: Both right shifts set C (`flags_out[2]`) to bit 0 of the operand before the shift, including for shift amounts of 0 and of 32 or more. V (`flags_out[3]`) is set to `v_in`.
- R6: The shift amount is the whole 8-bit immediate. An amount of 32 or more gives 0 for the logical right shift and the left shift, and gives 32 copies of the sign bit for the arithmetic right shift.
- R7: Left shift sets C to `c_in` and V to `v_in`.
- R8: Signed multiply sign-extends the immediate and forms the 64-bit two's-complement product. The low word goes to `result` and the high word to `hi_word`, and C and V are cleared.
- R9: Unsigned multiply zero-extends the immediate and treats the operand as unsigned. In every other respect it follows R8.
- R10: `hi_we` is raised, together with `res_valid`, only for the two multiplies. `hi_word` changes only when `hi_we` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Single-cycle strobe presenting an operation |
| op_byte | input | 8 | Second opcode byte that selects the operation |
| opnd | input | 32 | Register operand |
| imm | input | 8 | Immediate operand |
| c_in | input | 1 | Current carry flag from the status word |
| v_in | input | 1 | Current overflow flag from the status word |
| res_valid | output | 1 | Result and flags valid, one cycle |
| result | output | 32 | Registered result for the destination register |
| flags_out | output | 4 | Registered flags {V, C, N, Z}, Z in bit 0 |
| hi_we | output | 1 | Write enable for the multiply-high register |
| hi_word | output | 32 | Upper 32 bits of the last multiply product |

## Verification
Every result, flag vector and high word is due at the first rising edge after the operation is presented, and `res_valid` is high only for the cycle after that edge. The bench applies each operation at a falling edge and compares all outputs with its behavioural model at the next falling edge, half a period after the capture edge. At that same point it drops the strobe or presents the next operation. An ignored opcode byte is checked in the same cycle slot: the bench confirms that the strobe stayed low and that every output held its previous value.

// File: rtl/immop_pkg.sv
// Package: shared operation codes and flag bit positions for the
// register-immediate execution unit.
// Assumes the operation is named by the upper nibble of the opcode byte.
package immop_pkg;

    // Operation kind, equal to the upper nibble of the opcode byte
    typedef enum logic [3:0] {
        K_AND  = 4'h0,
        K_OR   = 4'h1,
        K_XOR  = 4'h2,
        K_ASR  = 4'h4,
        K_LSR  = 4'h5,
        K_ASL  = 4'h6,
        K_MUL  = 4'hA,
        K_MULU = 4'hB
    } op_kind_t;

    // Required lower nibble of every accepted opcode byte
    localparam logic [3:0] OP_SUFFIX = 4'h9;

    // Bit positions inside the flag vector
    localparam int FLG_Z = 0;
    localparam int FLG_N = 1;
    localparam int FLG_C = 2;
    localparam int FLG_V = 3;
    localparam int FLG_W = 4;

endpackage

// File: rtl/immop_decode.sv
// Module: immop_decode
// Turns the opcode byte into an operation kind and an accept bit.
// Assumes: purely combinational. Bytes outside the supported set are
// rejected, and the kind output is then don't-care.
module immop_decode
    import immop_pkg::*;
(
    input  logic [7:0] op_byte,
    output logic       op_ok,
    output op_kind_t   kind,
    output logic       is_mul
);

    logic known;

    // Decode the upper nibble and check the fixed lower nibble
    always_comb begin
        kind = op_kind_t'(op_byte[7:4]);
        unique case (op_byte[7:4])
            4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB: known = 1'b1;
            default:                                        known = 1'b0;
        endcase
        op_ok  = known && (op_byte[3:0] == OP_SUFFIX);
        is_mul = (op_byte[7:4] == 4'hA) || (op_byte[7:4] == 4'hB);
    end

endmodule

// File: rtl/immop_bitshift.sv
// Module: immop_bitshift
// Bitwise operations with the zero-extended immediate, and the three
// shifts by the full immediate value.
// Assumes: combinational. Shift amounts at or above DATA_W saturate in
// the natural way: zero fill, or sign fill for the arithmetic shift.
module immop_bitshift
    import immop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  op_kind_t            kind,
    input  logic [DATA_W-1:0]   a,
    input  logic [IMM_W-1:0]    imm,
    output logic [DATA_W-1:0]   res
);

    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_z;

    // Zero-extend the immediate for the bitwise operations
    assign imm_z = {{PAD_W{1'b0}}, imm};

    // Pick the bitwise or shift result for the decoded kind
    always_comb begin
        unique case (kind)
            K_OR:    res = a | imm_z;
            K_XOR:   res = a ^ imm_z;
            K_ASR:   res = DATA_W'($signed(a) >>> imm);
            K_LSR:   res = a >> imm;
            K_ASL:   res = a << imm;
            default: res = a & imm_z;
        endcase
    end

endmodule

// File: rtl/immop_mult.sv
// Module: immop_mult
// One shared multiplier for the signed and unsigned register-by-immediate
// products. Both operands are extended to the product width, sign or zero
// according to sgn, and the product is taken modulo 2^PROD_W, which gives
// the correct two's-complement result in both cases.
// Assumes: combinational. The caller registers the outputs.
module immop_mult #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              sgn,
    input  logic [DATA_W-1:0] a,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] lo,
    output logic [DATA_W-1:0] hi
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int IPAD_W = PROD_W - IMM_W;

    logic [PROD_W-1:0] a_w;
    logic [PROD_W-1:0] b_w;
    logic [PROD_W-1:0] prod;

    // Extend both operands to the product width, then multiply
    always_comb begin
        a_w  = {{DATA_W{sgn & a[DATA_W-1]}}, a};
        b_w  = {{IPAD_W{sgn & imm[IMM_W-1]}}, imm};
        prod = a_w * b_w;
        lo   = prod[DATA_W-1:0];
        hi   = prod[PROD_W-1:DATA_W];
    end

endmodule

// File: rtl/immop_exec.sv
// Module: immop_exec (top)
// Register-immediate execution unit. It decodes the opcode byte, computes
// the result, applies the flag rule of each operation and registers all
// outputs one edge after an accepted strobe.
// Assumes: the register file and the status word live outside the unit.
// c_in and v_in carry the present C and V for the operations that keep them.
module immop_exec
    import immop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    input  logic [DATA_W-1:0] opnd,
    input  logic [IMM_W-1:0]  imm,
    input  logic              c_in,
    input  logic              v_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic [FLG_W-1:0]  flags_out,
    output logic              hi_we,
    output logic [DATA_W-1:0] hi_word
);

    op_kind_t          kind;
    logic              op_ok;
    logic              is_mul;
    logic              accept;
    logic [DATA_W-1:0] bs_res;
    logic [DATA_W-1:0] mul_lo;
    logic [DATA_W-1:0] mul_hi;
    logic [DATA_W-1:0] res_d;
    logic [FLG_W-1:0]  flg_d;

    immop_decode u_dec (
        .op_byte (op_byte),
        .op_ok   (op_ok),
        .kind    (kind),
        .is_mul  (is_mul)
    );

    immop_bitshift #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_bs (
        .kind (kind),
        .a    (opnd),
        .imm  (imm),
        .res  (bs_res)
    );

    immop_mult #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_mul (
        .sgn (kind == K_MUL),
        .a   (opnd),
        .imm (imm),
        .lo  (mul_lo),
        .hi  (mul_hi)
    );

    assign accept = op_valid && op_ok;

    // Select the result and apply the flag rule of each operation
    always_comb begin
        res_d = is_mul ? mul_lo : bs_res;
        flg_d[FLG_Z] = (res_d == '0);
        flg_d[FLG_N] = res_d[DATA_W-1];
        unique case (kind)
            K_ASR, K_LSR: begin
                flg_d[FLG_C] = opnd[0];
                flg_d[FLG_V] = v_in;
            end
            K_ASL: begin
                flg_d[FLG_C] = c_in;
                flg_d[FLG_V] = v_in;
            end
            default: begin
                flg_d[FLG_C] = 1'b0;
                flg_d[FLG_V] = 1'b0;
            end
        endcase
    end

    // Output registers: load on an accepted strobe, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            hi_we     <= 1'b0;
            result    <= '0;
            flags_out <= '0;
            hi_word   <= '0;
        end else begin
            res_valid <= accept;
            hi_we     <= accept && is_mul;
            if (accept) begin
                result    <= res_d;
                flags_out <= flg_d;
            end
            if (accept && is_mul) begin
                hi_word <= mul_hi;
            end
        end
    end

    // R2: a valid result only follows a strobe
    a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_valid));

    // R1: a rejected or absent operation leaves the result unchanged
    a_r1_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(result) && $stable(flags_out) && !res_valid));

    // R4: Z and N agree with the registered result
    a_r4_zn_match: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flags_out[FLG_Z] == (result == '0)
                       && flags_out[FLG_N] == result[DATA_W-1]));

    // R7: left shift passes C and V through
    a_r7_asl_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_ASL) |=> (flags_out[FLG_C] == $past(c_in)
                                       && flags_out[FLG_V] == $past(v_in)));

    // R10: the high-word write only comes with a valid result
    a_r10_hi_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |-> res_valid);

    // R10: the high word changes only on a multiply write
    a_r10_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_we |-> $stable(hi_word));

endmodule

// File: tb/immop_exec_test.sv
module immop_exec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic [31:0] opnd = '0;
    logic [7:0]  imm = '0;
    logic        c_in = 1'b0;
    logic        v_in = 1'b0;
    logic        res_valid;
    logic [31:0] result;
    logic [3:0]  flags_out;
    logic        hi_we;
    logic [31:0] hi_word;

    int errors = 0;
    int checks = 0;

    // Harness state: register file, status word, multiply-high register
    logic [31:0] regs [16];
    logic [3:0]  psw = '0;
    logic [31:0] mdr = '0;
    logic [31:0] last_res = '0;

    always #10 clk = ~clk;

    immop_exec uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .opnd(opnd), .imm(imm), .c_in(c_in), .v_in(v_in),
        .res_valid(res_valid), .result(result), .flags_out(flags_out),
        .hi_we(hi_we), .hi_word(hi_word)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model of one operation
    task automatic ref_exec(input logic [7:0] code, input logic [31:0] a,
                            input logic [7:0] im, input logic [3:0] pin,
                            output bit ok, output logic [31:0] r,
                            output logic [31:0] hi, output logic [3:0] f,
                            output bit mul);
        longint signed sp;
        longint unsigned up;
        bit c;
        bit v;
        ok = 1; mul = 0; hi = 0; r = 0;
        c = 0; v = 0;
        case (code)
            8'h09: r = a & {24'h0, im};
            8'h19: r = a | {24'h0, im};
            8'h29: r = a ^ {24'h0, im};
            8'h49: begin
                r = a;
                for (int i = 0; i < im; i++) r = {r[31], r[31:1]};
                c = a[0]; v = pin[3];
            end
            8'h59: begin
                r = a;
                for (int i = 0; i < im; i++) r = {1'b0, r[31:1]};
                c = a[0]; v = pin[3];
            end
            8'h69: begin
                r = a;
                for (int i = 0; i < im; i++) r = {r[30:0], 1'b0};
                c = pin[2]; v = pin[3];
            end
            8'hA9: begin
                sp = longint'(signed'(a)) * longint'(signed'(im));
                r = sp[31:0]; hi = sp[63:32]; mul = 1;
            end
            8'hB9: begin
                up = longint'(a) * longint'(im);
                r = up[31:0]; hi = up[63:32]; mul = 1;
            end
            default: ok = 0;
        endcase
        f = {v, c, r[31], (r == 32'h0)};
    endtask

    // Present one operation on a falling edge and check it one edge later
    task automatic do_op(input string tag, input logic [7:0] code,
                         input int rn, input logic [7:0] im);
        bit ok;
        bit mul;
        logic [31:0] er;
        logic [31:0] eh;
        logic [3:0]  ef;
        logic [3:0]  old_f;
        logic [31:0] old_h;
        ref_exec(code, regs[rn], im, psw, ok, er, eh, ef, mul);
        old_f = flags_out;
        old_h = hi_word;
        op_byte = code; opnd = regs[rn]; imm = im;
        c_in = psw[2]; v_in = psw[3];
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        if (ok) begin
            chk(tag, "res_valid", res_valid, 1);
            chk(tag, "result", result, er);
            chk(tag, "flags", flags_out, ef);
            chk("R10", "hi_we", hi_we, mul);
            if (mul) chk(tag, "hi_word", hi_word, eh);
            else     chk("R10", "hi_word held", hi_word, old_h);
            regs[rn] = er; psw = ef; last_res = er;
            if (mul) mdr = eh;
        end else begin
            chk(tag, "res_valid", res_valid, 0);
            chk(tag, "hi_we", hi_we, 0);
            chk(tag, "result held", result, last_res);
            chk(tag, "flags held", flags_out, old_f);
            chk(tag, "hi_word held", hi_word, old_h);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2", "reset res_valid", res_valid, 0);
        chk("R2", "reset result", result, 0);
        chk("R2", "reset flags", flags_out, 0);
        chk("R2", "reset hi", {hi_we, hi_word}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 bitwise ops clear C and V, Z from zero result (R4)
        regs[1] = 32'hFFFF_FF0F; psw = 4'b1100;
        do_op("R3", 8'h09, 1, 8'hF0);
        regs[2] = 32'h1234_0000; psw = 4'b1100;
        do_op("R3", 8'h19, 2, 8'h81);
        regs[3] = 32'h8000_0000; psw = 4'b1100;
        do_op("R4", 8'h29, 3, 8'h01);
        // R2 back-to-back, one-cycle valid pulse
        do_op("R2", 8'h29, 3, 8'h01);
        @(negedge clk);
        chk("R2", "valid pulse ends", res_valid, 0);

        // R5 right shifts: C from bit 0 before shift, V passes through
        regs[4] = 32'h8000_0003; psw = 4'b1000;
        do_op("R5", 8'h49, 4, 8'h01);
        regs[5] = 32'h0000_0005; psw = 4'b0000;
        do_op("R5", 8'h59, 5, 8'h00);
        regs[5] = 32'h0000_0004; psw = 4'b1100;
        do_op("R5", 8'h59, 5, 8'h02);

        // R6 full 8-bit amount
        regs[6] = 32'hFFFF_FFFF; psw = 4'b0000;
        do_op("R6", 8'h59, 6, 8'd40);
        regs[7] = 32'h8000_0000;
        do_op("R6", 8'h49, 7, 8'd200);
        regs[8] = 32'h7000_0001;
        do_op("R6", 8'h69, 8, 8'd32);
        regs[8] = 32'h0000_0001;
        do_op("R6", 8'h69, 8, 8'd31);

        // R7 left shift keeps C and V
        regs[9] = 32'h0000_00F0; psw = 4'b1100;
        do_op("R7", 8'h69, 9, 8'd4);
        psw = 4'b0000;
        do_op("R7", 8'h69, 9, 8'd1);

        // R8 signed multiply
        regs[10] = 32'hFFFF_FFFE; psw = 4'b1100;
        do_op("R8", 8'hA9, 10, 8'h83);
        regs[11] = 32'h7FFF_FFFF;
        do_op("R8", 8'hA9, 11, 8'h7F);
        regs[12] = 32'h0000_1000;
        do_op("R8", 8'hA9, 12, 8'hFF);

        // R9 unsigned multiply
        regs[13] = 32'hFFFF_FFFF; psw = 4'b1100;
        do_op("R9", 8'hB9, 13, 8'hFF);
        regs[14] = 32'h0000_1000;
        do_op("R9", 8'hB9, 14, 8'hFF);

        // R1 rejected bytes leave everything held
        do_op("R1", 8'h39, 1, 8'h12);
        do_op("R1", 8'h0A, 1, 8'h12);
        do_op("R1", 8'hA8, 13, 8'h05);

        // R10 non-multiply after multiply keeps hi_word
        regs[15] = 32'h0000_0011;
        do_op("R10", 8'h19, 15, 8'h02);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule